// File: doc/BRIEF.md
# Trigger Window Acquisition Controller

This controller looks for trigger events by opening a measurement window of fixed, selectable length and checking whether a trigger arrives inside it. A window opens straight after an external reset, and again after every internal reset the controller generates itself. When a window closes, one of two things happens. If a trigger was seen, the controller sends a one-cycle read command to a memory-transfer interface. It then keeps the window closed until that interface signals that the transfer is done. If no trigger was seen, the controller issues a one-cycle internal reset and opens a new window. In this way it scans on its own until a window holds a trigger.

The 2-bit range select picks one of four window lengths, in steps of one base unit. With the default of 1000 cycles per unit (10 µs at a 100 MHz reference clock), the lengths are 1000, 2000, 3000 and 4000 cycles. The range select is captured on the clock edge that opens the window and is held until the window closes.

Top module: `trig_window_ctrl`

## Requirements
- R1: While `ext_rst_n` is low, `win_open`, `rd_cmd` and `int_rst` are all 0. On the first rising clock edge after `ext_rst_n` goes high, the window opens (`win_open` = 1).
- R2: A window stays open for exactly (range_sel + 1) × STEP_CYCLES consecutive cycles, where STEP_CYCLES defaults to 1000. Code 0 gives 1000 cycles and code 3 gives 4000 cycles.
- R3: `range_sel` is sampled on the edge that opens the window. Changing it while the window is open does not change that window's length.
- R4: If `trig` is high in at least one cycle while `win_open` is 1, `rd_cmd` is high for exactly one cycle, in the cycle right after the last open cycle.
- R5: If `trig` is not high in any open cycle, `int_rst` is high for exactly one cycle, in the cycle right after the last open cycle. The window opens again in the following cycle.
- R6: After `rd_cmd`, `win_open` stays 0 until `xfer_done` is sampled high. The cycle after that, `int_rst` pulses for one cycle, and the window reopens in the cycle after the pulse.
- R7: A `trig` pulse that arrives while the controller is reading out (the `rd_cmd` cycle or while waiting for `xfer_done`), or during the `int_rst` cycle, is ignored. It does not cause a read at the end of the next window.
- R8: The trigger-seen record is cleared by the internal reset and by the external reset. A window that follows a read, or follows an external reset that interrupted a window with a trigger, ends in `int_rst` if that window itself has no trigger.
- R9: A trigger in the first open cycle of a window counts, and so does a trigger in the last open cycle.
- R10: At most one of `win_open`, `rd_cmd` and `int_rst` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous assert |
| trig | input | 1 | Trigger strobe, sampled on each rising edge |
| range_sel | input | 2 | Window length code, length = (code + 1) × STEP_CYCLES |
| xfer_done | input | 1 | Memory transfer finished, sampled while waiting after a read |
| win_open | output | 1 | Measurement window open |
| rd_cmd | output | 1 | One-cycle read command to the memory-transfer interface |
| int_rst | output | 1 | One-cycle internal reset, precedes every reopened window |

## Verification
Some cases are hard to reach from the ports. One is a trigger that lands exactly on the first or the last cycle of a window. Another is a trigger that falls in the read-out wait or in the internal-reset cycle and must then leave no trace in the next window. The stimulus counts open cycles from the falling edge at which `win_open` is first seen, and places `trig` on a chosen cycle index. To produce the stray triggers, it pulses `trig` while the controller waits for `xfer_done` and on the exact `int_rst` cycle. It then checks that the following trigger-free window retries instead of reading. A second directed case asserts the external reset in the middle of a window that has already seen a trigger, and checks that the record does not survive the reset.

// File: rtl/trig_window_ctrl.sv
module trig_window_ctrl #(
  parameter int STEP_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       ext_rst_n,
  input  logic       trig,
  input  logic [1:0] range_sel,
  input  logic       xfer_done,
  output logic       win_open,
  output logic       rd_cmd,
  output logic       int_rst
);
  localparam int MAX_LEN = 4 * STEP_CYCLES;
  localparam int CW = $clog2(MAX_LEN);

  typedef enum logic [2:0] {ST_START, ST_RST, ST_OPEN, ST_READ, ST_WAIT} state_t;

  state_t          state;
  logic [1:0]      sel_q;
  logic [CW-1:0]   cnt;
  logic            seen;
  logic [CW-1:0]   last_idx;
  logic            at_end;

  assign last_idx = CW'((32'(sel_q) + 32'd1) * STEP_CYCLES - 1);
  assign at_end   = (cnt == last_idx);

  assign win_open = (state == ST_OPEN);
  assign rd_cmd   = (state == ST_READ);
  assign int_rst  = (state == ST_RST);

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      state <= ST_START;
      sel_q <= '0;
      cnt   <= '0;
      seen  <= 1'b0;
    end else begin
      case (state)
        ST_START, ST_RST: begin
          state <= ST_OPEN;
          sel_q <= range_sel;
          cnt   <= '0;
          seen  <= 1'b0;
        end
        ST_OPEN: begin
          cnt <= cnt + 1'b1;
          if (trig) seen <= 1'b1;
          if (at_end) state <= (seen || trig) ? ST_READ : ST_RST;
        end
        ST_READ: state <= ST_WAIT;
        ST_WAIT: if (xfer_done) state <= ST_RST;
        default: state <= ST_START;
      endcase
    end
  end
endmodule

module trig_window_ctrl_chk (
  input logic clk,
  input logic ext_rst_n,
  input logic win_open,
  input logic rd_cmd,
  input logic int_rst
);
  AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $onehot0({win_open, rd_cmd, int_rst})); // R10
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!ext_rst_n)
    rd_cmd |=> !rd_cmd); // R4
  AST_RD_AFTER_WIN: assert property (@(posedge clk) disable iff (!ext_rst_n)
    rd_cmd |-> $past(win_open)); // R4
  AST_CLOSE_ACTION: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $fell(win_open) |-> (rd_cmd || int_rst)); // R5
  AST_RST_REOPEN: assert property (@(posedge clk) disable iff (!ext_rst_n)
    int_rst |=> win_open); // R5
  AST_READ_CLOSED: assert property (@(posedge clk) disable iff (!ext_rst_n)
    rd_cmd |=> !win_open); // R6
endmodule

bind trig_window_ctrl trig_window_ctrl_chk u_chk (.*);

// File: tb/tb_trig_window_ctrl.sv
module tb_trig_window_ctrl;
  localparam int STEP = 1000;
  localparam int NVEC = 7;
  localparam logic [15:0] NONE = 16'hFFFF;
  // {sel[20:19], exp_read[18], sel_change[17], noise[16], trig_offset[15:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, NONE},
    {2'd1, 1'b1, 1'b0, 1'b0, 16'd0},
    {2'd3, 1'b1, 1'b0, 1'b1, 16'd3999},
    {2'd2, 1'b0, 1'b0, 1'b0, NONE},
    {2'd0, 1'b1, 1'b1, 1'b0, 16'd500},
    {2'd3, 1'b0, 1'b1, 1'b0, NONE},
    {2'd1, 1'b1, 1'b0, 1'b0, 16'd1999}
  };

  logic clk = 0;
  logic ext_rst_n = 0;
  logic trig = 0;
  logic [1:0] range_sel = 0;
  logic xfer_done = 0;
  logic win_open, rd_cmd, int_rst;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  trig_window_ctrl #(.STEP_CYCLES(STEP)) dut (
    .clk(clk), .ext_rst_n(ext_rst_n), .trig(trig), .range_sel(range_sel),
    .xfer_done(xfer_done), .win_open(win_open), .rd_cmd(rd_cmd), .int_rst(int_rst));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge where int_rst is high; returns at the next such negedge.
  task automatic run_window(input logic [20:0] v);
    logic [1:0] sel = v[20:19];
    logic exp_rd = v[18];
    logic chg = v[17];
    logic noise = v[16];
    int toff = (v[15:0] == NONE) ? -1 : int'(v[15:0]);
    int n = 0;
    int len = (int'(sel) + 1) * STEP;
    range_sel = sel;
    @(negedge clk);
    chk(win_open === 1'b1, "R5 reopen after int_rst", int'(win_open), 1);
    while (win_open === 1'b1 && n < 5000) begin
      trig = (n == toff);
      if (chg && n == 5) range_sel = ~sel;
      n++;
      @(negedge clk);
    end
    trig = 0;
    chk(n == len, chg ? "R3 length held after select change" : "R2 window length", n, len);
    if (toff == 0 || toff == len - 1)
      chk(rd_cmd === 1'b1, "R9 edge-cycle trigger counted", int'(rd_cmd), 1);
    chk(rd_cmd === exp_rd, "R4 read at close", int'(rd_cmd), int'(exp_rd));
    chk(int_rst === !exp_rd, "R5 internal reset at close", int'(int_rst), int'(!exp_rd));
    if (exp_rd) begin
      @(negedge clk);
      chk(rd_cmd === 1'b0, "R4 single-cycle read", int'(rd_cmd), 0);
      for (int i = 0; i < 8; i++) begin
        if (noise) trig = (i % 2 == 0);
        @(negedge clk);
        chk(win_open === 1'b0 && int_rst === 1'b0, "R6 closed until transfer done",
            int'(win_open), 0);
      end
      trig = 0;
      xfer_done = 1;
      @(negedge clk);
      xfer_done = 0;
      chk(int_rst === 1'b1, "R6 internal reset after transfer done", int'(int_rst), 1);
      if (noise) trig = 1;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!win_open && !rd_cmd && !int_rst, "R1 outputs idle in reset",
        int'({win_open, rd_cmd, int_rst}), 0);
    range_sel = 2'd0;
    ext_rst_n = 1;
    @(negedge clk);
    chk(win_open === 1'b1, "R1 window opens after reset", int'(win_open), 1);
    // Trigger early, then external reset mid-window: record must not survive (R8).
    trig = 1;
    @(negedge clk);
    trig = 0;
    repeat (20) @(negedge clk);
    ext_rst_n = 0;
    @(negedge clk);
    chk(!win_open && !rd_cmd && !int_rst, "R1 outputs idle in mid-window reset",
        int'({win_open, rd_cmd, int_rst}), 0);
    ext_rst_n = 1;
    @(negedge clk);
    chk(win_open === 1'b1, "R1 window reopens after reset", int'(win_open), 1);
    begin
      int n = 1;
      while (win_open === 1'b1 && n < 5000) begin
        @(negedge clk);
        if (win_open === 1'b1) n++;
      end
      chk(n == STEP, "R2 first window length", n, STEP);
      chk(int_rst === 1'b1 && rd_cmd === 1'b0, "R8 external reset clears trigger record",
          int'(int_rst), 1);
    end
    for (int k = 0; k < NVEC; k++) run_window(VEC[k]);
    // Vector 3 verified R7 (noise before it) and R8 (after a read); R10 by AST_OUT_EXCL.
    trig = 0;
    summary();
    $finish;
  end
endmodule